// File: doc/BRIEF.md
# Radix-4 Multiplier Sequencing Controller

This block is the state machine that sequences a sequential radix-4 (two bits per cycle) multiplier whose two operands arrive one after the other on a single shared 8-bit input bus. It has an idle state and three phases. A ready pulse starts a run. The first phase captures the multiplicand, the second captures the multiplier from the same bus, and the third runs a fixed series of add-and-shift-by-2 steps. The controller then rests in a done state until the next ready starts another run.

The state code is an output port. An external mode decoder turns it into load, shift and hold controls for the datapath. The controller also drives a multiplicand-load enable and a done flag, both Moore outputs. Reset is synchronous and active high. With the default of four steps there are eight states, coded 0 to 7 in 3 bits.

Top module: `mseq_ctrl`

## Requirements
- R1: When rst is high at a rising clock edge, the state code becomes 0 and both mcand_load and done become 0, whatever ready is.
- R2: In state 0, ready low at the edge keeps the state at 0, and ready high moves it to state 1.
- R3: mcand_load is high exactly when the state code is 1, so it lasts one cycle per run.
- R4: State 1 always advances to state 2, whether ready is high or low.
- R5: State 2 (multiplier capture from the shared bus) always advances to state 3, whether ready is high or low.
- R6: Each add-and-shift state, codes 3 through 6, advances to the next code on every edge, whether ready is high or low.
- R7: done is high exactly when the state code is 7.
- R8: In state 7, ready low keeps the state at 7, and ready high moves it to state 1.
- R9: Take the edge at which ready is high in state 0 as edge 1. The state is 1 after edge 1, and done first reads high after edge 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Start request, seen only in the idle and done states |
| state_code | output | 3 | Registered state code, 0 to 7 |
| mcand_load | output | 1 | Multiplicand capture enable, high in state 1 |
| done | output | 1 | Result valid, high in state 7 |

## Verification
The state code is itself an output, so a wrong next-state choice is visible at the ports one edge after the decision. It shows as a skipped, repeated or misplaced code, or as a load or done flag out of step with the code. A controller that honoured ready in a busy state would leave the expected sequence in that same cycle. A controller that ignored ready in idle or done would fail to reach state 1 on the next edge. Random ready and reset patterns, checked against a reference model every cycle, expose such faults at the first cycle where the design's state differs from the model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int unsigned SEQ_STEPS_DEF = 4;
    localparam int unsigned PH_IDLE       = 0;
    localparam int unsigned PH_LD_MCAND   = 1;
    localparam int unsigned PH_LD_MPLIER  = 2;
    localparam int unsigned PH_FIRST_STEP = 3;
endpackage

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
#(
    parameter int unsigned SW   = 3,
    parameter int unsigned LAST = 7
) (
    input  logic [SW-1:0] cur,
    input  logic          ready,
    output logic [SW-1:0] nxt
);
    localparam logic [SW-1:0] C_IDLE  = SW'(PH_IDLE);
    localparam logic [SW-1:0] C_START = SW'(PH_LD_MCAND);
    localparam logic [SW-1:0] C_LAST  = SW'(LAST);

    logic legal;

    generate
        if ((2 ** SW) > (LAST + 1)) begin : g_sparse
            assign legal = (cur <= C_LAST);
        end else begin : g_dense
            assign legal = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!legal) begin
            nxt = C_IDLE;
        end else if (cur == C_IDLE) begin
            nxt = ready ? C_START : C_IDLE;
        end else if (cur == C_LAST) begin
            nxt = ready ? C_START : C_LAST;
        end else begin
            nxt = cur + SW'(1);
        end
    end
endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
#(
    parameter int unsigned SW   = 3,
    parameter int unsigned LAST = 7
) (
    input  logic [SW-1:0] code,
    output logic          load,
    output logic          fin
);
    always_comb begin
        load = (code == SW'(PH_LD_MCAND));
        fin  = (code == SW'(LAST));
    end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
#(
    parameter int unsigned STEPS = SEQ_STEPS_DEF,
    localparam int unsigned NST  = STEPS + 4,
    localparam int unsigned LAST = NST - 1,
    localparam int unsigned SW   = $clog2(NST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ready,
    output logic [SW-1:0] state_code,
    output logic          mcand_load,
    output logic          done
);
    typedef struct packed {
        logic [SW-1:0] code;
        logic          load;
        logic          fin;
    } ctrl_t;

    ctrl_t         ctrl_d, ctrl_q;
    logic [SW-1:0] code_nxt, code_sel;
    logic          load_nxt, fin_nxt;

    mseq_next #(.SW(SW), .LAST(LAST)) i_next (
        .cur   (ctrl_q.code),
        .ready (ready),
        .nxt   (code_nxt)
    );

    assign code_sel = rst ? SW'(PH_IDLE) : code_nxt;

    mseq_decode #(.SW(SW), .LAST(LAST)) i_decode (
        .code (code_sel),
        .load (load_nxt),
        .fin  (fin_nxt)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.code = code_sel;
        ctrl_d.load = load_nxt;
        ctrl_d.fin  = fin_nxt;
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign state_code = ctrl_q.code;
    assign mcand_load = ctrl_q.load;
    assign done       = ctrl_q.fin;

    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (state_code == '0 && !mcand_load && !done));

    // R2
    p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (state_code == SW'(PH_IDLE)) |=>
        (state_code == ($past(ready) ? SW'(PH_LD_MCAND) : SW'(PH_IDLE))));

    // R3
    p_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mcand_load |=> !mcand_load);
    p_load_state_r3: assert property (@(posedge clk) disable iff (rst)
        mcand_load |-> (state_code == SW'(PH_LD_MCAND)));

    // R4
    p_mcand_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (state_code == SW'(PH_LD_MCAND)) |=> (state_code == SW'(PH_LD_MPLIER)));

    // R5
    p_mplier_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (state_code == SW'(PH_LD_MPLIER)) |=> (state_code == SW'(PH_FIRST_STEP)));

    // R6
    p_step_adv_r6: assert property (@(posedge clk) disable iff (rst)
        (state_code >= SW'(PH_FIRST_STEP) && state_code < SW'(LAST)) |=>
        (state_code == $past(state_code) + SW'(1)));

    // R7
    p_done_state_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_code == SW'(LAST)));
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mcand_load, done}));

    // R8
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_code == SW'(LAST) && !ready) |=> (state_code == SW'(LAST)));
    p_done_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (state_code == SW'(LAST) && ready) |=> (state_code == SW'(PH_LD_MCAND)));
endmodule

// File: tb/test_mseq_ctrl.sv
module test_mseq_ctrl;
    localparam int STEPS = 4;
    localparam int LAST  = STEPS + 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ready = 1'b0;
    logic [2:0] state_code;
    logic       mcand_load;
    logic       done;

    int checks = 0;
    int errors = 0;
    int exp_st = 0;

    always #4 clk = ~clk;

    mseq_ctrl #(.STEPS(STEPS)) i_mseq_ctrl (
        .clk(clk), .rst(rst), .ready(ready),
        .state_code(state_code), .mcand_load(mcand_load), .done(done)
    );

    function automatic int model_next(int cur, logic rdy, logic rs);
        if (rs) return 0;
        if (cur == 0) return rdy ? 1 : 0;
        if (cur == LAST) return rdy ? 1 : LAST;
        return cur + 1;
    endfunction

    function automatic string tag_for(int prev, logic rs);
        if (rs) return "R1";
        if (prev == 0) return "R2";
        if (prev == 1) return "R4";
        if (prev == 2) return "R5";
        if (prev == LAST) return "R8";
        return "R6";
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_outputs(string req);
        check(req, int'(state_code), exp_st);
        check("R3", int'(mcand_load), (exp_st == 1) ? 1 : 0);
        check("R7", int'(done), (exp_st == LAST) ? 1 : 0);
    endtask

    // one cycle: drive at negedge, take the edge, compare at the next negedge
    task automatic cycle(logic rs, logic rdy);
        int prev = exp_st;
        rst   = rs;
        ready = rdy;
        exp_st = model_next(prev, rdy, rs);
        @(negedge clk);
        check_outputs(tag_for(prev, rs));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int lat;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // reset with ready high: R1
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        // idle waits: R2
        repeat (3) cycle(1'b0, 1'b0);
        // full run with ready held high in the busy states: R4 R5 R6
        cycle(1'b0, 1'b1);
        repeat (6) cycle(1'b0, 1'b1);
        // rest in done: R8
        repeat (3) cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b1);
        // reset in mid run: R1
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        cycle(1'b1, 1'b0);
        repeat (2) cycle(1'b0, 1'b0);
        // latency from start to done: R9
        lat = 0;
        cycle(1'b0, 1'b1);
        lat++;
        check("R9", int'(state_code), 1);
        while (!done && lat < 20) begin
            cycle(1'b0, 1'b0);
            lat++;
        end
        check("R9", lat, LAST);
        // random ready and reset
        for (int i = 0; i < 3000; i++) begin
            logic rs = (($urandom % 40) == 0);
            logic rd = (($urandom % 3) == 0);
            cycle(rs, rd);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule